// File: doc/BRIEF.md
# Configurable Audio Frame Serializer

This block is a master-mode audio transmitter. It pulls parallel sample words from a valid/ready word interface and shifts them, most significant bit first, onto one serial data line. It also drives the bit clock and the frame sync for that line. The bit clock comes from dividing the system clock by an even ratio that software sets. Every serial output comes straight from a flop.

Run-time configuration sets the shape of the frame:
- how many slots a frame holds;
- the width of slot 0 and, separately, the width of every other slot;
- the length of the sync pulse in bit clocks;
- whether sync leads the frame by one bit;
- the active level of sync;
- which bit-clock edge launches data.

With these settings one engine produces two-slot stereo framing (justified or one-bit-delayed), short and long PCM sync, and a thirteen-slot layout whose 16-bit first slot is followed by 20-bit slots. The configuration must be held stable while `enable` is high. Dropping `enable` returns the block to idle.

Top module: `frame_serializer`

## Requirements
- R1: The frame holds `cfg_words_m1`+1 slots. Slot 0 uses the first-slot width and all later slots use the other-slot width, and the pattern repeats frame after frame.
- R2: Slot 0 carries the low `cfg_first_bits_m1`+1 bits of its word, and every other slot carries the low `cfg_other_bits_m1`+1 bits of its word. Bits go out most significant first, and words are sent in the order they were accepted.
- R3: The active sync pulse lasts `cfg_fs_len_m1`+1 bit clocks.
- R4: With `cfg_fs_early`=0, sync becomes active on the first bit of slot 0. With `cfg_fs_early`=1, it becomes active one bit earlier, on the last bit of the previous frame. In that case a single zero lead bit with active sync goes out right after enable.
- R5: With `cfg_fs_pol`=0 sync is active high, and with 1 it is active low. While the block is disabled, sync rests at its inactive level.
- R6: With `cfg_bclk_pol`=0, new data and sync appear as the bit clock falls, to be sampled on its rise. With 1 they appear as it rises. While the block is disabled, the bit clock rests at the level opposite to `cfg_bclk_pol`.
- R7: Each bit period lasts 2×(`cfg_half_div_m1`+1) system clocks.
- R8: `word_ready` is high only when the block is enabled and its one-word holding register is empty. An accepted word is held until the next slot start takes it.
- R9: If no word is held at a slot start, the slot is sent as zeros and `underrun` pulses high for exactly one system clock.
- R10: During reset and while disabled, `ser_data`, `underrun` and `word_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the serializer; low returns it to idle |
| cfg_bclk_pol | input | 1 | Bit-clock level at which data is launched |
| cfg_fs_pol | input | 1 | 0: sync active high, 1: sync active low |
| cfg_fs_early | input | 1 | Sync leads the frame by one bit |
| cfg_fs_len_m1 | input | $clog2(WORD_W) | Sync length in bit clocks, minus one |
| cfg_words_m1 | input | $clog2(MAX_WORDS) | Slots per frame, minus one |
| cfg_first_bits_m1 | input | $clog2(WORD_W) | Slot 0 width in bits, minus one |
| cfg_other_bits_m1 | input | $clog2(WORD_W) | Width of the other slots in bits, minus one |
| cfg_half_div_m1 | input | DIV_W | Half bit period in system clocks, minus one |
| word_valid | input | 1 | A word is offered |
| word_data | input | WORD_W | Offered word, right-aligned |
| word_ready | output | 1 | The holding register can take a word |
| ser_bclk | output | 1 | Bit clock |
| ser_fsync | output | 1 | Frame sync |
| ser_data | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse when a slot starts with no word |

## Verification
The bench builds the block with WORD_W=32, MAX_WORDS=16 and DIV_W=8. This reaches full 32-bit slots, single-bit slots and frames of up to sixteen slots, thirteen-slot frames with mixed widths among them. Division ratios are kept small (half periods of 1 to 4 clocks), so the tightest case can be reached: one-bit slots at a two-clock bit period, where the holding register must refill between consecutive slot starts. Directed stereo, PCM and thirteen-slot cases run alongside random frame shapes and polarities. A starved run covers the zero-fill and underrun path.

// File: rtl/afs_pkg.sv
package afs_pkg;
  // Sequencer state of the framer.
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/afs_bitclk.sv
// Divides the system clock into bit periods. A launch pulse marks the
// cycle on which the framer registers its next bit.
module afs_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bclk_pol,
  input  logic [DIV_W-1:0] half_m1,
  output logic             bclk,
  output logic             launch
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;  // 1: next wrap starts a new bit
  logic             wrap;

  assign wrap   = (cnt_q == half_m1);
  assign launch = run & wrap & phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      bclk    <= ~bclk_pol;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      bclk    <= phase_q ? bclk_pol : ~bclk_pol;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/afs_wordbuf.sv
// One-entry holding register between the word interface and the shifter.
module afs_wordbuf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pull,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  assign in_ready = en & ~full;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
    end else if (pull) begin
      full <= 1'b0;
    end
  end

  // Data path without reset so it maps onto plain fabric flops.
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data <= in_data;
  end
endmodule

// File: rtl/afs_framer.sv
// Tracks slot and bit position, shifts words out MSB first and shapes sync.
module afs_framer
  import afs_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(WORD_W),
  localparam int FRM_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              launch,
  input  logic              fs_early,
  input  logic              fs_pol,
  input  logic [LEN_W-1:0]  fs_len_m1,
  input  logic [FRM_W-1:0]  words_m1,
  input  logic [LEN_W-1:0]  first_m1,
  input  logic [LEN_W-1:0]  other_m1,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  output logic              pull,
  output logic              sdata,
  output logic              fsync,
  output logic              underrun
);
  localparam logic [LEN_W-1:0] TOP_BIT = LEN_W'(WORD_W - 1);

  seq_state_e        st_q;
  logic [LEN_W-1:0]  bit_q;
  logic [FRM_W-1:0]  slot_q;
  logic [WORD_W-1:0] sh_q;
  logic [LEN_W-1:0]  sync_left_q;

  logic [LEN_W-1:0]  cur_m1;
  logic              slot_start, frame_first, frame_last, in_lead, in_run;
  logic [WORD_W-1:0] src, aligned;
  logic              next_bit, trig, fs_act;
  logic [LEN_W-1:0]  sync_nxt;

  assign in_lead     = (st_q == SEQ_LEAD);
  assign in_run      = (st_q == SEQ_RUN);
  assign cur_m1      = (slot_q == '0) ? first_m1 : other_m1;
  assign slot_start  = (bit_q == '0);
  assign frame_first = slot_start && (slot_q == '0);
  assign frame_last  = (bit_q == cur_m1) && (slot_q == words_m1);
  assign pull        = launch && in_run && slot_start;
  assign src         = hold_full ? hold_data : '0;
  assign aligned     = src << (TOP_BIT - cur_m1);
  assign next_bit    = slot_start ? aligned[WORD_W-1] : sh_q[WORD_W-1];
  assign trig        = fs_early ? (in_lead || (in_run && frame_last))
                                : (in_run && frame_first);

  always_comb begin
    fs_act   = 1'b0;
    sync_nxt = sync_left_q;
    if (trig) begin
      fs_act   = 1'b1;
      sync_nxt = fs_len_m1;
    end else if (sync_left_q != '0) begin
      fs_act   = 1'b1;
      sync_nxt = sync_left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q        <= SEQ_IDLE;
      bit_q       <= '0;
      slot_q      <= '0;
      sync_left_q <= '0;
      sdata       <= 1'b0;
      fsync       <= fs_pol;
      underrun    <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (st_q == SEQ_IDLE) begin
        st_q <= fs_early ? SEQ_LEAD : SEQ_RUN;
      end else if (launch) begin
        sync_left_q <= sync_nxt;
        fsync       <= fs_act ^ fs_pol;
        if (in_lead) begin
          sdata <= 1'b0;
          st_q  <= SEQ_RUN;
        end else begin
          sdata    <= next_bit;
          underrun <= slot_start & ~hold_full;
          if (bit_q == cur_m1) begin
            bit_q  <= '0;
            slot_q <= (slot_q == words_m1) ? '0 : slot_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (launch && in_run) sh_q <= slot_start ? (aligned << 1) : (sh_q << 1);
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int  WORD_W    = 32,
  parameter int  MAX_WORDS = 16,
  parameter int  DIV_W     = 8,
  localparam int LEN_W     = $clog2(WORD_W),
  localparam int FRM_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_bclk_pol,
  input  logic              cfg_fs_pol,
  input  logic              cfg_fs_early,
  input  logic [LEN_W-1:0]  cfg_fs_len_m1,
  input  logic [FRM_W-1:0]  cfg_words_m1,
  input  logic [LEN_W-1:0]  cfg_first_bits_m1,
  input  logic [LEN_W-1:0]  cfg_other_bits_m1,
  input  logic [DIV_W-1:0]  cfg_half_div_m1,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              ser_bclk,
  output logic              ser_fsync,
  output logic              ser_data,
  output logic              underrun
);
  logic              launch, pull, hold_full;
  logic [WORD_W-1:0] hold_data;

  afs_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .bclk_pol (cfg_bclk_pol),
    .half_m1  (cfg_half_div_m1),
    .bclk     (ser_bclk),
    .launch   (launch)
  );

  afs_wordbuf #(.WORD_W(WORD_W)) u_wordbuf (
    .clk      (clk),
    .rst      (rst),
    .en       (enable),
    .in_valid (word_valid),
    .in_data  (word_data),
    .in_ready (word_ready),
    .pull     (pull),
    .full     (hold_full),
    .data     (hold_data)
  );

  afs_framer #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .en        (enable),
    .launch    (launch),
    .fs_early  (cfg_fs_early),
    .fs_pol    (cfg_fs_pol),
    .fs_len_m1 (cfg_fs_len_m1),
    .words_m1  (cfg_words_m1),
    .first_m1  (cfg_first_bits_m1),
    .other_m1  (cfg_other_bits_m1),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .pull      (pull),
    .sdata     (ser_data),
    .fsync     (ser_fsync),
    .underrun  (underrun)
  );
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic cfg_bclk_pol,
  input logic cfg_fs_pol,
  input logic word_valid,
  input logic word_ready,
  input logic ser_bclk,
  input logic ser_fsync,
  input logic ser_data,
  input logic underrun
);
  AST_DATA_ON_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (rst || !enable)
    ($past(enable) && !$stable(ser_data)) |-> (ser_bclk == cfg_bclk_pol)); // R6

  AST_BCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (ser_bclk != $past(cfg_bclk_pol))); // R6

  AST_FSYNC_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (ser_fsync == $past(cfg_fs_pol))); // R5

  AST_READY_DROPS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready); // R8

  AST_UNDERRUN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun); // R9

  AST_UNDERRUN_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    underrun |-> $past(enable)); // R9
endmodule

bind frame_serializer frame_serializer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .cfg_bclk_pol (cfg_bclk_pol),
  .cfg_fs_pol   (cfg_fs_pol),
  .word_valid   (word_valid),
  .word_ready   (word_ready),
  .ser_bclk     (ser_bclk),
  .ser_fsync    (ser_fsync),
  .ser_data     (ser_data),
  .underrun     (underrun)
);

// File: tb/frame_serializer_test.sv
`timescale 1ns/1ps
module frame_serializer_test;
  localparam int WORD_W = 32;
  localparam int MAX_WORDS = 16;
  localparam int DIV_W = 8;
  localparam int CAP = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic cfg_bclk_pol = 1'b0, cfg_fs_pol = 1'b0, cfg_fs_early = 1'b0;
  logic [4:0] cfg_fs_len_m1 = '0, cfg_first_bits_m1 = '0, cfg_other_bits_m1 = '0;
  logic [3:0] cfg_words_m1 = '0;
  logic [DIV_W-1:0] cfg_half_div_m1 = '0;
  logic word_valid = 1'b0;
  logic [WORD_W-1:0] word_data = '0;
  logic word_ready, ser_bclk, ser_fsync, ser_data, underrun;

  always #10 clk = ~clk;  // 50 MHz

  frame_serializer #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .enable(enable),
    .cfg_bclk_pol(cfg_bclk_pol), .cfg_fs_pol(cfg_fs_pol), .cfg_fs_early(cfg_fs_early),
    .cfg_fs_len_m1(cfg_fs_len_m1), .cfg_words_m1(cfg_words_m1),
    .cfg_first_bits_m1(cfg_first_bits_m1), .cfg_other_bits_m1(cfg_other_bits_m1),
    .cfg_half_div_m1(cfg_half_div_m1),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .ser_bclk(ser_bclk), .ser_fsync(ser_fsync), .ser_data(ser_data), .underrun(underrun)
  );

  int checks = 0, errors = 0, cyc = 0, n_acc = 0;
  logic clr = 1'b0;
  logic [31:0] salt = 32'h0;
  logic mon_on = 1'b0, prev_b = 1'b0;
  int ncap = 0, ucnt = 0, last_t = 0, per_bad = 0, per_exp = 2;
  logic cap_d [CAP];
  logic cap_f [CAP];
  int   cap_u [CAP];

  function automatic logic [31:0] mix(int k);
    logic [31:0] x;
    x = (32'(k) * 32'h9E3779B1) ^ salt;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) n_acc <= 0;
    else if (word_valid && word_ready) n_acc <= n_acc + 1;
  end

  always @(negedge clk) word_data = mix(n_acc);

  // Sample edge: bit clock leaves the launch level.
  always @(negedge clk) begin
    if (mon_on) begin
      if (underrun) ucnt++;
      if (prev_b == cfg_bclk_pol && ser_bclk != cfg_bclk_pol && ncap < CAP) begin
        cap_d[ncap] = ser_data;
        cap_f[ncap] = ser_fsync;
        cap_u[ncap] = ucnt;
        if (ncap > 0 && (cyc - last_t) != per_exp) per_bad++;
        last_t = cyc;
        ncap++;
      end
    end
    prev_b = ser_bclk;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got cycle %0d expected below 190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", msg, got, exp);
    end
  endtask

  // Expected {data, sync level} for captured bit k under the current setup.
  function automatic logic [1:0] expect_bit(int k, bit vld, output bit slot_st);
    int j, w0, wn, frm, fl, f, pos, s, b, w, idx;
    logic [31:0] word;
    logic d, act;
    slot_st = 1'b0;
    if (cfg_fs_early) begin
      if (k == 0) return {1'b0, 1'b1 ^ cfg_fs_pol};
      j = k - 1;
    end else j = k;
    w0 = int'(cfg_first_bits_m1) + 1;
    wn = int'(cfg_other_bits_m1) + 1;
    frm = int'(cfg_words_m1);
    fl = w0 + frm * wn;
    f = j / fl;
    pos = j % fl;
    if (pos < w0) begin s = 0; b = pos; w = w0; end
    else begin s = 1 + (pos - w0) / wn; b = (pos - w0) % wn; w = wn; end
    slot_st = (b == 0);
    idx = f * (frm + 1) + s;
    word = mix(idx);
    d = vld ? word[w-1-b] : 1'b0;
    if (cfg_fs_early) act = (pos == fl - 1) || (pos < int'(cfg_fs_len_m1));
    else act = (pos <= int'(cfg_fs_len_m1));
    return {d, act ^ cfg_fs_pol};
  endfunction

  task automatic run_case(input int id, input bit bp, input bit fp, input bit early,
                          input int fsl, input int frm, input int w0, input int wn,
                          input int half, input bit vld, input int nbits);
    int ntot, bad_d, bad_f, first_d, first_f, n_slot;
    logic [1:0] e;
    bit ss;
    @(negedge clk);
    enable = 1'b0;
    cfg_bclk_pol = bp; cfg_fs_pol = fp; cfg_fs_early = early;
    cfg_fs_len_m1 = 5'(fsl); cfg_words_m1 = 4'(frm);
    cfg_first_bits_m1 = 5'(w0); cfg_other_bits_m1 = 5'(wn);
    cfg_half_div_m1 = DIV_W'(half);
    word_valid = vld;
    salt = $urandom;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    ncap = 0; ucnt = 0; per_bad = 0; per_exp = 2 * (half + 1);
    ntot = nbits + (early ? 1 : 0);
    mon_on = 1'b1;
    enable = 1'b1;
    if (!vld) begin
      @(negedge clk); @(negedge clk);
      check(word_ready == 1'b1, $sformatf("R8 case %0d ready with empty holding register", id),
            int'(word_ready), 1);
    end
    while (ncap < ntot) @(negedge clk);
    enable = 1'b0;
    mon_on = 1'b0;
    bad_d = 0; bad_f = 0; first_d = -1; first_f = -1; n_slot = 0;
    for (int k = 0; k < ntot; k++) begin
      e = expect_bit(k, vld, ss);
      if (ss) n_slot++;
      if (cap_d[k] !== e[1]) begin bad_d++; if (first_d < 0) first_d = k; end
      if (cap_f[k] !== e[0]) begin bad_f++; if (first_f < 0) first_f = k; end
    end
    if (first_d >= 0) begin
      e = expect_bit(first_d, vld, ss);
      check(1'b0, $sformatf("R1/R2 case %0d data at bit %0d", id, first_d),
            int'(cap_d[first_d]), int'(e[1]));
    end else check(1'b1, "", 0, 0);
    if (first_f >= 0) begin
      e = expect_bit(first_f, vld, ss);
      check(1'b0, $sformatf("R3/R4/R5 case %0d sync at bit %0d", id, first_f),
            int'(cap_f[first_f]), int'(e[0]));
    end else check(1'b1, "", 0, 0);
    check(per_bad == 0, $sformatf("R7 case %0d bit periods off from %0d clocks", id, per_exp),
          per_bad, 0);
    check(cap_u[ntot-1] == (vld ? 0 : n_slot),
          $sformatf("R9 case %0d underrun pulses", id), cap_u[ntot-1], vld ? 0 : n_slot);
    repeat (3) @(negedge clk);
    check(ser_data == 1'b0 && word_ready == 1'b0 && underrun == 1'b0,
          $sformatf("R10 case %0d idle outputs", id),
          int'({ser_data, word_ready, underrun}), 0);
    check(ser_bclk == ~bp && ser_fsync == fp, $sformatf("R5/R6 case %0d idle levels", id),
          int'({ser_bclk, ser_fsync}), int'({~bp, fp}));
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(ser_data == 1'b0 && underrun == 1'b0 && word_ready == 1'b0,
          "R10 reset outputs", int'({ser_data, underrun, word_ready}), 0);
    check(ser_bclk == 1'b1 && ser_fsync == 1'b0, "R5/R6 reset levels",
          int'({ser_bclk, ser_fsync}), 2);

    // Directed framings.
    run_case(1, 1, 1, 1, 15, 1, 15, 15, 1, 1, 200);   // delayed stereo
    run_case(2, 1, 0, 0, 15, 1, 15, 15, 0, 1, 200);   // justified stereo
    run_case(3, 0, 0, 1, 0, 1, 15, 15, 2, 1, 160);    // short sync PCM
    run_case(4, 0, 0, 0, 7, 1, 15, 15, 0, 1, 160);    // long sync PCM
    run_case(5, 1, 0, 1, 15, 12, 15, 19, 0, 1, 600);  // thirteen slots
    run_case(6, 0, 1, 0, 0, 15, 0, 0, 0, 1, 80);      // one-bit slots, tightest refill
    run_case(7, 1, 0, 0, 31, 2, 31, 31, 3, 1, 300);   // full-width slots
    run_case(8, 0, 0, 0, 3, 3, 7, 7, 1, 0, 120);      // starved: zeros and underrun

    // Random frame shapes.
    for (int r = 0; r < 6; r++) begin
      int frm, w0, wn, fl, fsl, nb;
      frm = int'($urandom % 16);
      w0 = int'($urandom % 32);
      wn = int'($urandom % 32);
      fl = (w0 + 1) + frm * (wn + 1);
      fsl = int'($urandom % ((fl < 32) ? fl : 32));
      nb = 2 * fl + 20;
      if (nb > 1000) nb = 1000;
      run_case(10 + r, 1'($urandom), 1'($urandom), 1'($urandom), fsl, frm, w0, wn,
               int'($urandom % 4), 1, nb);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule